// File: doc/BRIEF.md
# Quad-Precision Unordered Floating-Point Comparator

This block compares two IEEE binary128 operands and returns a four-bit condition code that tells whether the first operand is less than, greater than or equal to the second, or whether the two are unordered. A quiet NaN on either side only marks the pair as unordered. A signaling NaN also raises an invalid-operation flag. The code goes to a condition-code output and to an identical floating-point condition copy. A three-bit destination field index travels beside the operands, so the downstream write-back logic knows which condition field to update.

The block accepts one compare per cycle, marked by a valid strobe, and registers the result one cycle later. A facility-enable input gates the whole operation. When a request arrives while the facility is disabled, the block reports facility-unavailable and leaves every result and flag exactly as it was. Operand widths are parameters (exponent and fraction width), and the defaults give binary128.

Top module: `qpc_compare`

## Requirements
- R1: One cycle after a strobe with the facility enabled, `out_valid` is 1 and `out_field` equals the field index given with that strobe. In every other cycle `out_valid` is 0.
- R2: For two non-NaN operands, the ordering is sign-magnitude. A negative operand is below a positive one. For two negative operands the magnitude order is inverted. Subnormals order by magnitude. Exactly one of LT, GT, EQ is set, and UN is 0.
- R3: Positive zero and negative zero compare equal in every combination.
- R4: An infinity (all-ones exponent, zero fraction) orders by its sign against finite values. Two infinities of the same sign compare equal.
- R5: If either operand is a NaN (all-ones exponent, nonzero fraction), the code is exactly UN: LT, GT and EQ are 0.
- R6: `snan_flag` is 1 after a compare exactly when at least one operand is a signaling NaN (fraction MSB 0). A quiet NaN (fraction MSB 1) alone leaves it 0. The flag is recomputed on each compare, so an earlier value never persists into a later compare.
- R7: `fpcc` always equals `cc`. Both use the bit order {LT, GT, EQ, UN}, with LT in bit 3 and UN in bit 0.
- R8: A strobe with `fac_en` = 0 gives `fac_unavail` = 1 in the next cycle. In that cycle `out_valid` is 0, and `cc`, `fpcc`, `snan_flag` and `out_field` are unchanged.
- R9: After reset, `out_valid`, `cc`, `fpcc`, `out_field`, `snan_flag` and `fac_unavail` are all 0.
- R10: In cycles without a strobe, the result outputs hold their values and `fac_unavail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compare request strobe |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| cr_field | input | 3 | Destination condition-field index |
| fac_en | input | 1 | Facility enable |
| out_valid | output | 1 | Registered result valid |
| cc | output | 4 | Condition code {LT, GT, EQ, UN} |
| out_field | output | 3 | Field index of the completed compare |
| fpcc | output | 4 | Floating-point condition copy {FL, FG, FE, FU} |
| snan_flag | output | 1 | Invalid operation: signaling NaN seen |
| fac_unavail | output | 1 | Request refused, facility disabled |

## Verification
The bench builds the block with EXP_W = 3 and FRAC_W = 2, which gives six-bit operands. At that size every ordered pair of operands (4096 pairs) can be compared. The sweep therefore reaches both zero signs, every subnormal, both infinities and both NaN kinds on each side, and it compares each result against a real-number model. Because compares run back to back, the sweep also shows the signaling-NaN flag clearing between compares. Separate sequences cover refused requests while the facility is disabled and idle cycles.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  // Condition code, MSB first: less, greater, equal, unordered
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic un;
  } qpc_cond_t;

  // Operand classification
  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } qpc_class_t;

  localparam int unsigned QPC_FIELD_W = 3;
endpackage

// File: rtl/qpc_classify.sv
module qpc_classify
  import qpc_pkg::*;
#(
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned FRAC_W = 112,
  localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W,
  localparam int unsigned MAG_W = EXP_W + FRAC_W
) (
  input  logic [OP_W-1:0]  op,
  output logic             sign,
  output logic [MAG_W-1:0] mag,
  output qpc_class_t       cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  function automatic qpc_class_t classify(input logic [EXP_W-1:0] e,
                                          input logic [FRAC_W-1:0] f);
    qpc_class_t c;
    c.nan  = (&e) && (|f);
    c.snan = c.nan && !f[FRAC_W-1];
    c.zero = !(|e) && !(|f);
    return c;
  endfunction

  assign sign   = op[OP_W-1];
  assign exp_f  = op[MAG_W-1:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];
  assign mag    = op[MAG_W-1:0];
  assign cls    = classify(exp_f, frac_f);
endmodule

// File: rtl/qpc_order.sv
module qpc_order #(
  parameter int unsigned MAG_W = 127
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             zero_a,
  input  logic             zero_b,
  output logic             a_lt,
  output logic             a_gt,
  output logic             a_eq
);
  // Returns {lt, gt, eq} for ordered (non-NaN) operands
  function automatic logic [2:0] order3(input logic sa, input logic sb,
                                        input logic [MAG_W-1:0] ma,
                                        input logic [MAG_W-1:0] mb,
                                        input logic za, input logic zb);
    logic m_lt, m_gt;
    m_lt = ma < mb;
    m_gt = ma > mb;
    if (za && zb)       return 3'b001;
    else if (sa != sb)  return sa ? 3'b100 : 3'b010;
    else if (!m_lt && !m_gt) return 3'b001;
    else if (sa)        return {m_gt, m_lt, 1'b0};
    else                return {m_lt, m_gt, 1'b0};
  endfunction

  assign {a_lt, a_gt, a_eq} = order3(sign_a, sign_b, mag_a, mag_b, zero_a, zero_b);
endmodule

// File: rtl/qpc_compare.sv
module qpc_compare
  import qpc_pkg::*;
#(
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned FRAC_W = 112,
  localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W,
  localparam int unsigned MAG_W = EXP_W + FRAC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [OP_W-1:0]        op_a,
  input  logic [OP_W-1:0]        op_b,
  input  logic [QPC_FIELD_W-1:0] cr_field,
  input  logic                   fac_en,
  output logic                   out_valid,
  output logic [3:0]             cc,
  output logic [QPC_FIELD_W-1:0] out_field,
  output logic [3:0]             fpcc,
  output logic                   snan_flag,
  output logic                   fac_unavail
);
  logic [OP_W-1:0]  ops   [2];
  logic             sgn   [2];
  logic [MAG_W-1:0] mags  [2];
  qpc_class_t       cls   [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    qpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[i]),
      .sign(sgn[i]),
      .mag (mags[i]),
      .cls (cls[i])
    );
  end

  logic ord_lt, ord_gt, ord_eq;
  qpc_order #(.MAG_W(MAG_W)) u_ord (
    .sign_a(sgn[0]),
    .sign_b(sgn[1]),
    .mag_a (mags[0]),
    .mag_b (mags[1]),
    .zero_a(cls[0].zero),
    .zero_b(cls[1].zero),
    .a_lt  (ord_lt),
    .a_gt  (ord_gt),
    .a_eq  (ord_eq)
  );

  // Named internal events
  logic      do_cmp, blocked, any_nan, any_snan;
  qpc_cond_t cond_nxt;

  assign do_cmp   = in_valid && fac_en;
  assign blocked  = in_valid && !fac_en;
  assign any_nan  = cls[0].nan || cls[1].nan;
  assign any_snan = cls[0].snan || cls[1].snan;

  always_comb begin
    if (any_nan) cond_nxt = '{lt: 1'b0, gt: 1'b0, eq: 1'b0, un: 1'b1};
    else         cond_nxt = '{lt: ord_lt, gt: ord_gt, eq: ord_eq, un: 1'b0};
  end

  qpc_cond_t               cc_q, fpcc_q;
  logic                    valid_q, snan_q, unavail_q;
  logic [QPC_FIELD_W-1:0]  field_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      unavail_q <= 1'b0;
      cc_q      <= '0;
      fpcc_q    <= '0;
      snan_q    <= 1'b0;
      field_q   <= '0;
    end else begin
      valid_q   <= do_cmp;
      unavail_q <= blocked;
      if (do_cmp) begin
        cc_q    <= cond_nxt;
        fpcc_q  <= cond_nxt;
        snan_q  <= any_snan;
        field_q <= cr_field;
      end
    end
  end

  assign out_valid   = valid_q;
  assign fac_unavail = unavail_q;
  assign cc          = cc_q;
  assign fpcc        = fpcc_q;
  assign snan_flag   = snan_q;
  assign out_field   = field_q;

  // Cycles-since-reset guard for $past
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(do_cmp)));
  // R1
  field_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid) |-> (out_field == $past(cr_field)));
  // R2
  single_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(cc) == 1));
  // R5
  nan_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(do_cmp && any_nan)) |-> (cc == 4'b0001));
  // R6
  snan_implies_un_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && snan_flag) |-> cc[0]);
  // R7
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fpcc == cc));
  // R8
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(blocked)) |-> (fac_unavail && !out_valid && $stable(cc) && $stable(snan_flag)));
endmodule

// File: tb/sim_qpc_compare.sv
module sim_qpc_compare;
  localparam int E = 3;
  localparam int F = 2;
  localparam int W = 1 + E + F;
  localparam int BIAS = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [2:0]   cr_field = '0;
  logic         fac_en = 1'b0;
  logic         out_valid, snan_flag, fac_unavail;
  logic [3:0]   cc, fpcc;
  logic [2:0]   out_field;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  qpc_compare #(.EXP_W(E), .FRAC_W(F)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .cr_field(cr_field), .fac_en(fac_en), .out_valid(out_valid), .cc(cc),
    .out_field(out_field), .fpcc(fpcc), .snan_flag(snan_flag), .fac_unavail(fac_unavail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  function automatic bit is_nan(input logic [W-1:0] x);
    return (x[W-2:F] == 3'd7) && (x[F-1:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [W-1:0] x);
    return is_nan(x) && (x[F-1] == 1'b0);
  endfunction
  function automatic bit is_inf(input logic [W-1:0] x);
    return (x[W-2:F] == 3'd7) && (x[F-1:0] == 0);
  endfunction
  function automatic real value(input logic [W-1:0] x);
    int  e;
    real m;
    e = int'(x[W-2:F]);
    if (e == 7)      m = 1.0e9;
    else if (e == 0) m = (real'(x[F-1:0]) / 4.0) * (2.0 ** (1 - BIAS));
    else             m = (1.0 + real'(x[F-1:0]) / 4.0) * (2.0 ** (e - BIAS));
    return x[W-1] ? -m : m;
  endfunction

  task automatic compare(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] fld);
    logic [3:0] exp_cc;
    string tag;
    real va, vb;
    va = value(a);
    vb = value(b);
    if (is_nan(a) || is_nan(b)) begin exp_cc = 4'b0001; tag = "R5"; end
    else begin
      exp_cc = {va < vb, va > vb, va == vb, 1'b0};
      if (a[W-2:0] == 0 && b[W-2:0] == 0) tag = "R3";
      else if (is_inf(a) || is_inf(b))    tag = "R4";
      else                                tag = "R2";
    end
    @(negedge clk);
    in_valid = 1'b1; fac_en = 1'b1; op_a = a; op_b = b; cr_field = fld;
    @(negedge clk);
    in_valid = 1'b0;
    chk(cc == exp_cc, tag, cc, exp_cc);
    chk(fpcc == exp_cc, "R7", fpcc, exp_cc);
    chk(snan_flag == (is_snan(a) || is_snan(b)), "R6", snan_flag, is_snan(a) || is_snan(b));
    chk(out_valid && out_field == fld, "R1", {out_valid, out_field}, {1'b1, fld});
  endtask

  initial begin
    logic [3:0] keep_cc;
    logic [2:0] keep_fld;
    logic       keep_sn;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk({out_valid, cc, fpcc, out_field, snan_flag, fac_unavail} == '0, "R9",
        {out_valid, cc, fpcc, out_field, snan_flag, fac_unavail}, 0);
    rst_n = 1'b1;

    // Exhaustive sweep covering R2..R7, R1
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        compare(W'(i), W'(j), 3'(i + j));

    // R10: idle cycles hold
    keep_cc = cc; keep_fld = out_field; keep_sn = snan_flag;
    repeat (3) @(negedge clk);
    chk(!out_valid && !fac_unavail && cc == keep_cc && out_field == keep_fld && snan_flag == keep_sn,
        "R10", {out_valid, fac_unavail, cc}, {2'b00, keep_cc});

    // R8: refused request leaves state alone (sNaN operand, new field)
    compare(6'b001000, 6'b000100, 3'd2);
    keep_cc = cc; keep_fld = out_field; keep_sn = snan_flag;
    @(negedge clk);
    in_valid = 1'b1; fac_en = 1'b0; op_a = 6'b011101; op_b = 6'b000000; cr_field = 3'd6;
    @(negedge clk);
    in_valid = 1'b0;
    chk(fac_unavail && !out_valid, "R8", {fac_unavail, out_valid}, 2'b10);
    chk(cc == keep_cc && fpcc == keep_cc, "R8", cc, keep_cc);
    chk(snan_flag == keep_sn && out_field == keep_fld, "R8", {snan_flag, out_field}, {keep_sn, keep_fld});
    @(negedge clk);
    chk(!fac_unavail, "R10", fac_unavail, 0);

    // R6: flag set by sNaN then cleared by a plain compare
    compare(6'b111101, 6'b000001, 3'd1);
    chk(snan_flag == 1'b1, "R6", snan_flag, 1);
    compare(6'b111110, 6'b000001, 3'd1);
    chk(snan_flag == 1'b0, "R6", snan_flag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule